// File: doc/BRIEF.md
# Store Drain Queue

This block holds the stores of one thread of an out-of-order core from the moment they are dispatched until the data cache has accepted them and reported them done. Stores claim a slot at the tail in program order. Later, an execute stage fills in the address, the size, up to `BYTES` bytes of data and two flags: one that marks a line-crossing access and one that marks a zero-fill store. A commit input tags every resident store older than a given sequence number. Only a store that is both filled and committed may leave the queue.

A writeback pointer walks forward from the oldest unsent store. It offers up to `PORTS` consecutive eligible stores per cycle on parallel request lanes, which use a valid/ready handshake. If the cache refuses a lane, the queue stops and holds that store. It offers nothing more until a retry pulse arrives, and then it re-offers the held store before anything newer. A slot is released only when the cache signals completion of the oldest in-flight stores. A squash input drops uncommitted stores younger than a given sequence number and pulls the tail back.

The ring has `SLOTS` slots, one of which is a sentinel. It therefore holds at most `SLOTS-1` stores.

Top module: `store_drain_queue`

## Requirements
- R1: After reset the queue is empty: `count` is 0, `empty` is 1, `full` is 0, `blocked` is 0, `alloc_idx` is 0 and no request lane is valid.
- R2: An accepted `alloc_valid` writes the store into slot `alloc_idx` and then advances `alloc_idx` by one, wrapping from `SLOTS-1` to 0. `full` is 1 exactly when `count` equals `SLOTS-1`. An allocation while full is ignored, so `count` and `alloc_idx` stay unchanged.
- R3: A store is offered to the cache only after it has been filled and also committed. A commit with sequence number C commits exactly the resident stores whose sequence number is strictly less than C, compared as unsigned numbers.
- R4: Request lane k (with k counted from 0) carries the k-th oldest unsent eligible store. A lane is valid only when every lower lane is valid. At most `PORTS` stores are offered per cycle. When the queue is empty, no lane is valid.
- R5: For a store filled with the zero flag set, the lane shows `req_zero`=1 and all-zero `req_data`, whatever data was filled.
- R6: A valid lane seen with its ready bit low sets `blocked` on the next cycle. Stores on lower, accepted lanes count as sent. While `blocked` is 1, no lane is valid.
- R7: A `retry` pulse while blocked clears `blocked` on the next cycle. Lane 0 then re-offers the refused store before any newer store.
- R8: Sending a store does not free its slot. `count` and `full` change only when bits of `done` are set. Each set bit of `done` releases the oldest in-flight store.
- R9: A squash with sequence number S removes every uncommitted store whose sequence number is greater than S. Committed stores survive. The next `alloc_idx` is the slot just after the youngest surviving store.
- R10: When a squash and an allocation occur in the same cycle, the squash wins and the allocation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the store being allocated |
| alloc_idx | output | $clog2(SLOTS) | Slot the next allocation will use |
| full | output | 1 | Occupancy has reached SLOTS-1 |
| empty | output | 1 | No resident stores |
| count | output | $clog2(SLOTS+1) | Number of resident stores |
| fill_valid | input | 1 | Write address, size and data into a slot |
| fill_idx | input | $clog2(SLOTS) | Slot being filled |
| fill_addr | input | ADDRW | Store address |
| fill_size | input | $clog2(BYTES+1) | Store size in bytes |
| fill_data | input | 8*BYTES | Store data |
| fill_zero | input | 1 | Store writes zeros and carries no payload |
| fill_split | input | 1 | Access crosses a line boundary |
| commit_valid | input | 1 | Commit stores older than commit_seq |
| commit_seq | input | SEQW | Commit boundary |
| squash_valid | input | 1 | Squash uncommitted stores younger than squash_seq |
| squash_seq | input | SEQW | Youngest surviving sequence number |
| req_valid | output | PORTS | Per-lane request valid |
| req_ready | input | PORTS | Per-lane cache acceptance |
| req_addr | output | PORTS*ADDRW | Per-lane address |
| req_size | output | PORTS*$clog2(BYTES+1) | Per-lane size |
| req_data | output | PORTS*8*BYTES | Per-lane data |
| req_zero | output | PORTS | Per-lane zero-fill flag |
| req_split | output | PORTS | Per-lane split flag |
| retry | input | 1 | Cache can take the refused store again |
| done | input | PORTS | Each set bit completes one oldest in-flight store |
| blocked | output | 1 | A refused store is waiting for retry |

## Verification
The hardest situation to reach is a partial refusal: two stores are offered together, the cache accepts lane 0 and refuses lane 1, and the writeback pointer must advance by exactly one. The bench commits two stores in the same cycle, holds `req_ready` at 01 for one edge, and then sends a retry. It expects lane 0 to carry the second store's address and lane 1 to be idle. A second hard case is a squash whose boundary lies below a committed store: the bench commits the oldest store, squashes below its sequence number, and observes through `alloc_idx` and `count` that only the uncommitted stores left.

// File: rtl/store_drain_queue.sv
module store_drain_queue #(
  parameter int SLOTS = 8,
  parameter int SEQW  = 16,
  parameter int ADDRW = 32,
  parameter int BYTES = 16,
  parameter int PORTS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 alloc_valid,
  input  logic [SEQW-1:0]                      alloc_seq,
  output logic [$clog2(SLOTS)-1:0]             alloc_idx,
  output logic                                 full,
  output logic                                 empty,
  output logic [$clog2(SLOTS+1)-1:0]           count,
  input  logic                                 fill_valid,
  input  logic [$clog2(SLOTS)-1:0]             fill_idx,
  input  logic [ADDRW-1:0]                     fill_addr,
  input  logic [$clog2(BYTES+1)-1:0]           fill_size,
  input  logic [8*BYTES-1:0]                   fill_data,
  input  logic                                 fill_zero,
  input  logic                                 fill_split,
  input  logic                                 commit_valid,
  input  logic [SEQW-1:0]                      commit_seq,
  input  logic                                 squash_valid,
  input  logic [SEQW-1:0]                      squash_seq,
  output logic [PORTS-1:0]                     req_valid,
  input  logic [PORTS-1:0]                     req_ready,
  output logic [PORTS*ADDRW-1:0]               req_addr,
  output logic [PORTS*$clog2(BYTES+1)-1:0]     req_size,
  output logic [PORTS*8*BYTES-1:0]             req_data,
  output logic [PORTS-1:0]                     req_zero,
  output logic [PORTS-1:0]                     req_split,
  input  logic                                 retry,
  input  logic [PORTS-1:0]                     done,
  output logic                                 blocked
);
  localparam int IW  = $clog2(SLOTS);
  localparam int CW  = $clog2(SLOTS+1);
  localparam int SW  = $clog2(BYTES+1);
  localparam int DW  = 8*BYTES;
  localparam int LIM = SLOTS-1;

  logic [SLOTS-1:0] vld_q, cwb_q, cmt_q, zero_q, split_q;
  logic [SEQW-1:0]  seq_q  [SLOTS];
  logic [ADDRW-1:0] addr_q [SLOTS];
  logic [SW-1:0]    size_q [SLOTS];
  logic [DW-1:0]    data_q [SLOTS];
  logic [IW-1:0]    head_q, wb_q, tail_q;
  logic [CW-1:0]    cnt_q, fly_q;
  logic             blk_q;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] i, input int n);
    int s;
    s = (int'(i) + n) % SLOTS;
    if (s < 0) s += SLOTS;
    return IW'(s);
  endfunction

  assign full      = cnt_q >= CW'(LIM);
  assign empty     = cnt_q == '0;
  assign count     = cnt_q;
  assign alloc_idx = tail_q;
  assign blocked   = blk_q;

  logic alloc_ok;
  assign alloc_ok = alloc_valid && !squash_valid && !full;

  logic [CW-1:0] unsent;
  assign unsent = cnt_q - fly_q;

  logic [IW-1:0] lane_idx [PORTS];

  always_comb begin
    int  used;
    logic run;
    used = 0;
    run  = !blk_q;
    for (int k = 0; k < PORTS; k++) begin
      lane_idx[k] = step(wb_q, k);
      req_valid[k] = run && (used < PORTS) && (k < int'(unsent)) &&
                     cwb_q[lane_idx[k]] && cmt_q[lane_idx[k]];
      if (req_valid[k]) used++;
      else run = 1'b0;
      req_addr[k*ADDRW +: ADDRW] = addr_q[lane_idx[k]];
      req_size[k*SW +: SW]       = size_q[lane_idx[k]];
      req_data[k*DW +: DW]       = zero_q[lane_idx[k]] ? '0 : data_q[lane_idx[k]];
      req_zero[k]                = zero_q[lane_idx[k]];
      req_split[k]               = split_q[lane_idx[k]];
    end
  end

  logic [CW-1:0] acc_n;
  logic          refused;

  always_comb begin
    logic go;
    acc_n   = '0;
    refused = 1'b0;
    go      = 1'b1;
    for (int k = 0; k < PORTS; k++) begin
      if (req_valid[k] && go) begin
        if (req_ready[k]) acc_n = acc_n + CW'(1);
        else begin
          refused = 1'b1;
          go      = 1'b0;
        end
      end
    end
  end

  logic [CW-1:0]    fr_n;
  logic [SLOTS-1:0] free_mask;

  always_comb begin
    int d;
    d = $countones(done);
    fr_n = (d > int'(fly_q)) ? fly_q : CW'(d);
    free_mask = '0;
    for (int k = 0; k < PORTS; k++)
      if (k < int'(fr_n)) free_mask[step(head_q, k)] = 1'b1;
  end

  logic [CW-1:0]    sq_n;
  logic [SLOTS-1:0] sq_mask;

  always_comb begin
    sq_mask = '0;
    sq_n    = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (squash_valid && vld_q[s] && !cmt_q[s] && seq_q[s] > squash_seq) begin
        sq_mask[s] = 1'b1;
        sq_n       = sq_n + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      cwb_q   <= '0;
      cmt_q   <= '0;
      zero_q  <= '0;
      split_q <= '0;
      head_q  <= '0;
      wb_q    <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      fly_q   <= '0;
      blk_q   <= 1'b0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (free_mask[s] || sq_mask[s]) begin
          vld_q[s] <= 1'b0;
        end else if (alloc_ok && tail_q == IW'(s)) begin
          vld_q[s]   <= 1'b1;
          cwb_q[s]   <= 1'b0;
          cmt_q[s]   <= 1'b0;
          zero_q[s]  <= 1'b0;
          split_q[s] <= 1'b0;
        end else if (vld_q[s]) begin
          if (fill_valid && fill_idx == IW'(s)) begin
            cwb_q[s]   <= 1'b1;
            zero_q[s]  <= fill_zero;
            split_q[s] <= fill_split;
          end
          if (commit_valid && seq_q[s] < commit_seq) cmt_q[s] <= 1'b1;
        end
      end
      if (squash_valid)  tail_q <= step(tail_q, -int'(sq_n));
      else if (alloc_ok) tail_q <= step(tail_q, 1);
      wb_q   <= step(wb_q, int'(acc_n));
      head_q <= step(head_q, int'(fr_n));
      fly_q  <= fly_q + acc_n - fr_n;
      cnt_q  <= cnt_q + CW'(alloc_ok) - fr_n - sq_n;
      if (refused)    blk_q <= 1'b1;
      else if (retry) blk_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (alloc_ok && tail_q == IW'(s)) seq_q[s] <= alloc_seq;
      if (fill_valid && fill_idx == IW'(s) && vld_q[s]) begin
        addr_q[s] <= fill_addr;
        size_q[s] <= fill_size;
        data_q[s] <= fill_data;
      end
    end
  end
endmodule

// File: rtl/store_drain_queue_chk.sv
module store_drain_queue_chk #(
  parameter int PORTS = 2,
  parameter int CW    = 4,
  parameter int DW    = 128,
  parameter int LIM   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full,
  input logic             blocked,
  input logic             retry,
  input logic [CW-1:0]    count,
  input logic [PORTS-1:0] req_valid,
  input logic [PORTS-1:0] req_ready,
  input logic [PORTS-1:0] req_zero,
  input logic [PORTS*DW-1:0] req_data
);
  // R2
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LIM));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> count <= $past(count));

  // R4
  lane_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid + 1'b1) & req_valid) == '0);

  // R4
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> req_valid == '0);

  // R6
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> req_valid == '0);

  // R6
  refuse_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_valid & ~req_ready)) |=> blocked);

  // R7
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked && retry) |=> !blocked);

  for (genvar k = 0; k < PORTS; k++) begin : g_lane
    // R5
    zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[k] && req_zero[k]) |-> req_data[k*DW +: DW] == '0);
  end
endmodule

bind store_drain_queue store_drain_queue_chk #(
  .PORTS(PORTS), .CW(CW), .DW(DW), .LIM(LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .full(full), .blocked(blocked), .retry(retry),
  .count(count), .req_valid(req_valid), .req_ready(req_ready),
  .req_zero(req_zero), .req_data(req_data)
);

// File: tb/store_drain_queue_tb.sv
module store_drain_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 8;
  localparam int P     = 2;
  localparam int IW    = 3;
  localparam int CW    = 4;
  localparam int SW    = 5;
  localparam int DW    = 128;
  localparam int AW    = 32;
  localparam int QW    = 16;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0; logic [QW-1:0] alloc_seq = 0;
  logic [IW-1:0] alloc_idx; logic full, empty; logic [CW-1:0] count;
  logic fill_valid = 0; logic [IW-1:0] fill_idx = 0; logic [AW-1:0] fill_addr = 0;
  logic [SW-1:0] fill_size = 0; logic [DW-1:0] fill_data = 0;
  logic fill_zero = 0, fill_split = 0;
  logic commit_valid = 0; logic [QW-1:0] commit_seq = 0;
  logic squash_valid = 0; logic [QW-1:0] squash_seq = 0;
  logic [P-1:0] req_valid, req_ready = 2'b11, req_zero, req_split, done = 0;
  logic [P*AW-1:0] req_addr; logic [P*SW-1:0] req_size; logic [P*DW-1:0] req_data;
  logic retry = 0, blocked;

  int vecs = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_drain_queue u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .full(full), .empty(empty), .count(count),
    .fill_valid(fill_valid), .fill_idx(fill_idx), .fill_addr(fill_addr),
    .fill_size(fill_size), .fill_data(fill_data), .fill_zero(fill_zero),
    .fill_split(fill_split), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_data(req_data), .req_zero(req_zero), .req_split(req_split),
    .retry(retry), .done(done), .blocked(blocked)
  );

  function automatic longint addr_of(int s);
    return 64'h1000 + longint'(s) * 16;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    alloc_valid = 0; fill_valid = 0; commit_valid = 0;
    squash_valid = 0; retry = 0; done = 0;
  endtask

  task automatic do_alloc(input int s, input int exp_idx, input string tag);
    chk(tag, alloc_idx, exp_idx);
    alloc_valid = 1; alloc_seq = QW'(s);
    tick();
  endtask

  task automatic do_fill(input int idx, input int s, input logic z);
    fill_valid = 1; fill_idx = IW'(idx); fill_addr = AW'(addr_of(s));
    fill_size = 5'd16; fill_zero = z; fill_split = 0;
    fill_data = z ? '1 : {8{QW'(s)}};
    tick();
  endtask

  task automatic t_reset();
    chk("R1 count", count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 blocked", blocked, 0);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 req_valid", req_valid, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 3; i++) do_alloc(10 + i, i, "R2 alloc_idx order");
    chk("R2 count", count, 3);
    for (int i = 0; i < 3; i++) do_fill(i, 10 + i, 0);
    chk("R3 filled not committed", req_valid, 0);
    commit_valid = 1; commit_seq = 12; tick();
    chk("R4 two lanes", req_valid, 3);
    chk("R4 lane0 addr", req_addr[31:0], addr_of(10));
    chk("R4 lane1 addr", req_addr[63:32], addr_of(11));
    tick();
    chk("R3 strict commit bound", req_valid, 0);
    chk("R8 sent not freed", count, 3);
    commit_valid = 1; commit_seq = 13; tick();
    chk("R4 third store lane0", req_valid, 1);
    chk("R4 third addr", req_addr[31:0], addr_of(12));
    tick();
    done = 2'b11; tick();
    chk("R8 two freed", count, 1);
    done = 2'b01; tick();
    chk("R8 all freed", count, 0);
    chk("R8 empty", empty, 1);
  endtask

  task automatic t_zero();
    do_alloc(20, 3, "R2 alloc_idx zero");
    commit_valid = 1; commit_seq = 21; tick();
    chk("R3 committed not filled", req_valid, 0);
    do_fill(3, 20, 1);
    chk("R5 valid", req_valid, 1);
    chk("R5 zero flag", req_zero[0], 1);
    chk("R5 data lo", req_data[63:0], 0);
    chk("R5 data hi", req_data[127:64], 0);
    chk("R5 size", req_size[4:0], 16);
    tick();
    done = 2'b01; tick();
    chk("R8 zero freed", count, 0);
  endtask

  task automatic t_block();
    do_alloc(30, 4, "R2 alloc_idx blk");
    do_alloc(31, 5, "R2 alloc_idx blk");
    do_fill(4, 30, 0);
    do_fill(5, 31, 0);
    commit_valid = 1; commit_seq = 32; tick();
    chk("R6 offered", req_valid, 3);
    req_ready = 2'b00; tick();
    chk("R6 blocked", blocked, 1);
    chk("R6 quiet", req_valid, 0);
    req_ready = 2'b11; tick();
    chk("R6 stays blocked", blocked, 1);
    chk("R6 still quiet", req_valid, 0);
    retry = 1; tick();
    chk("R7 unblocked", blocked, 0);
    chk("R7 reoffer lanes", req_valid, 3);
    chk("R7 held first", req_addr[31:0], addr_of(30));
    req_ready = 2'b01; tick();
    chk("R6 partial refusal", blocked, 1);
    req_ready = 2'b11; retry = 1; tick();
    chk("R7 only refused left", req_valid, 1);
    chk("R7 refused addr", req_addr[31:0], addr_of(31));
    tick();
    done = 2'b11; tick();
    chk("R8 blk freed", count, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 7; i++) do_alloc(40 + i, (6 + i) % SLOTS, "R2 wrap idx");
    chk("R2 count full", count, 7);
    chk("R2 full", full, 1);
    alloc_valid = 1; alloc_seq = 47; tick();
    chk("R2 ignored count", count, 7);
    chk("R2 ignored idx", alloc_idx, 5);
    for (int i = 0; i < 7; i++) do_fill((6 + i) % SLOTS, 40 + i, 0);
    commit_valid = 1; commit_seq = 50; tick();
    chk("R4 full lanes", req_valid, 3);
    for (int i = 0; i < 4; i++) tick();
    chk("R4 drained", req_valid, 0);
    chk("R8 full kept", full, 1);
    chk("R8 count kept", count, 7);
    done = 2'b11; tick();
    chk("R8 partial free", count, 5);
    chk("R8 not full", full, 0);
    done = 2'b11; tick();
    done = 2'b11; tick();
    done = 2'b01; tick();
    chk("R8 drained empty", count, 0);
  endtask

  task automatic t_squash();
    for (int i = 0; i < 4; i++) do_alloc(60 + i, (5 + i) % SLOTS, "R2 sq idx");
    do_fill(5, 60, 0);
    commit_valid = 1; commit_seq = 61; tick();
    chk("R3 sq offered", req_valid, 1);
    squash_valid = 1; squash_seq = 61; alloc_valid = 1; alloc_seq = 64; tick();
    chk("R9 count", count, 2);
    chk("R10 tail back", alloc_idx, 7);
    squash_valid = 1; squash_seq = 59; tick();
    chk("R9 committed kept", count, 1);
    chk("R9 tail after survivor", alloc_idx, 6);
    do_alloc(70, 6, "R9 realloc idx");
    chk("R9 count realloc", count, 2);
    done = 2'b01; tick();
    chk("R8 survivor freed", count, 1);
    squash_valid = 1; squash_seq = 69; tick();
    chk("R9 all gone", count, 0);
    chk("R9 empty", empty, 1);
    chk("R4 no lanes", req_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_zero();
    t_block();
    t_full();
    t_squash();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule